// File: doc/BRIEF.md
# Bus Cycle Sequencer with Bus Grant

This block steps a processor-style bus through its cycle states and drives the control lines that go with each cycle. A bus cycle runs T1, T2, T3, then zero or more wait states TW, then T4. When nothing is pending the bus sits in the idle state TI. The block drives the transceiver direction (`dt_r_o`) and the active-low data enable (`den_no`), strobes `done_o` in the final state, and takes part in a hold/acknowledge handshake so that another master can take the bus.

Two timing points fall in the middle of a clock: the data enable for reads and interrupt acknowledges, and the grant of the bus. A register stage clocked on the falling edge makes them. The block does not drive pads. Handing over the bus shows up as the `float_o` flag, and while that flag is high the control outputs read as a parked logic one.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: When `req_i` is high at a rising edge that ends TI or T4, and `hlda_o` is low, T1 begins. The states then follow as T1, T2, T3, any TW, T4. `done_o` is high for exactly the T4 clock, so it is never high on two consecutive clocks.
- R2: For a read or interrupt-acknowledge cycle, `den_no` goes low at the falling edge in the middle of T2 and returns high at the falling edge in the middle of T4. It is high throughout TI and T1.
- R3: For a write cycle, `den_no` goes low at the rising edge that starts T2 and returns high at the falling edge in the middle of T4.
- R4: `kind_i` is sampled when T1 begins. The codes are 3'b000 interrupt acknowledge, 3'b001 I/O read, 3'b010 I/O write, 3'b101 memory read and 3'b110 memory write. A code whose two low bits are 2'b10 is a write. `dt_r_o` is 1 for a write and 0 otherwise, from the start of T1 to the end of T4, and keeps that value in TI while the bus is not floated.
- R5: `ready_i` is sampled at the rising edge that ends T3 and at the edge that ends each TW. If it is low, another TW follows and `den_no` stays low. If it is high, T4 follows.
- R6: `hlda_o` rises only at a falling edge in the middle of TI or T4, and only when `hold_i` is high at that edge. A hold raised during T1 to TW waits for the middle of T4.
- R7: `float_o` rises at the same falling edge as `hlda_o`. While `float_o` is high, `dt_r_o` and `den_no` are both 1.
- R8: `hlda_o` falls at the first falling edge at which `hold_i` is low. `float_o` stays high after that edge and clears at the rising edge that starts the next T1.
- R9: No T1 begins while `hlda_o` is high. A request that is pending during a grant starts on the first rising edge after `hlda_o` falls.
- R10: While `rst_ni` is low, the bus is held in TI with `den_no` = 1, `dt_r_o` = 0, and `hlda_o`, `float_o` and `done_o` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; both edges are used |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | A bus cycle is wanted |
| kind_i | input | 3 | Cycle kind code, sampled when T1 begins |
| ready_i | input | 1 | Ends the wait states when high |
| hold_i | input | 1 | Another master asks for the bus (synchronous) |
| dt_r_o | output | 1 | Transceiver direction: 1 transmit, 0 receive |
| den_no | output | 1 | Transceiver data enable, active low |
| hlda_o | output | 1 | Hold acknowledge |
| float_o | output | 1 | The bus is released to the other master |
| done_o | output | 1 | High during T4 |

## Verification
The grant of the bus and the end of a cycle can land in the same clock. This happens when `hold_i` rises during T2 and is still high at mid-T4, while the next request is already pending. The bench sets up that case so that `done_o`, the release of the data enable, and the rise of `hlda_o` and `float_o` all fall inside one T4, with a request waiting behind them. A behavioural model in the bench predicts every output in both halves of each clock. Its verdict is that the grant wins: the pending cycle starts only on the first rising edge after the hold is dropped.

// File: rtl/bus_cyc_pkg.sv
package bus_cyc_pkg;
  localparam int unsigned KIND_W = 3;
  localparam logic [KIND_W-1:0] KIND_INTA   = 3'b000;
  localparam logic [KIND_W-1:0] KIND_IO_RD  = 3'b001;
  localparam logic [KIND_W-1:0] KIND_IO_WR  = 3'b010;
  localparam logic [KIND_W-1:0] KIND_MEM_RD = 3'b101;
  localparam logic [KIND_W-1:0] KIND_MEM_WR = 3'b110;

  typedef enum logic [2:0] {
    PH_TI, PH_T1, PH_T2, PH_T3, PH_TW, PH_T4
  } phase_e;

  function automatic logic kind_is_write(input logic [KIND_W-1:0] kind);
    return kind[1:0] == 2'b10;
  endfunction

  function automatic logic phase_may_grant(input phase_e ph);
    return (ph == PH_TI) || (ph == PH_T4);
  endfunction
endpackage

// File: rtl/bus_seq.sv
module bus_seq
  import bus_cyc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [KIND_W-1:0] kind_i,
  input  logic              ready_i,
  input  logic              hlda_i,
  output phase_e            phase_o,
  output logic              dir_o
);
  phase_e ph_q, ph_d;
  logic   dir_q, dir_d;

  always_comb begin
    ph_d  = ph_q;
    dir_d = dir_q;
    unique case (ph_q)
      PH_TI, PH_T4: begin
        if (req_i && !hlda_i) begin
          ph_d  = PH_T1;
          dir_d = kind_is_write(kind_i);
        end else begin
          ph_d = PH_TI;
        end
      end
      PH_T1:        ph_d = PH_T2;
      PH_T2:        ph_d = PH_T3;
      PH_T3, PH_TW: ph_d = ready_i ? PH_T4 : PH_TW;
      default:      ph_d = PH_TI;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_TI;
      dir_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      dir_q <= dir_d;
    end
  end

  assign phase_o = ph_q;
  assign dir_o   = dir_q;
endmodule

// File: rtl/bus_mid_stage.sv
// Falling-edge stage: mid-clock data enable, grant and float.
module bus_mid_stage
  import bus_cyc_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  phase_e phase_i,
  input  logic   hold_i,
  output logic   den_mid_o,
  output logic   hlda_o,
  output logic   float_o
);
  logic at_edge;
  logic den_q, hlda_q, float_q;
  logic den_d, hlda_d, float_d;

  assign at_edge = phase_may_grant(phase_i);

  always_comb begin
    den_d  = (phase_i == PH_T2) || (phase_i == PH_T3) || (phase_i == PH_TW);
    hlda_d = hold_i && (hlda_q || at_edge);
    if (hold_i && at_edge) float_d = 1'b1;
    else if (at_edge)      float_d = float_q;
    else                   float_d = 1'b0;
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      den_q   <= 1'b0;
      hlda_q  <= 1'b0;
      float_q <= 1'b0;
    end else begin
      den_q   <= den_d;
      hlda_q  <= hlda_d;
      float_q <= float_d;
    end
  end

  assign den_mid_o = den_q;
  assign hlda_o    = hlda_q;
  assign float_o   = float_q;
endmodule

// File: rtl/bus_out_drive.sv
module bus_out_drive
  import bus_cyc_pkg::*;
(
  input  phase_e phase_i,
  input  logic   dir_i,
  input  logic   den_mid_i,
  input  logic   float_q_i,
  output logic   dt_r_o,
  output logic   den_no,
  output logic   float_o,
  output logic   done_o
);
  logic floated, den_act;

  // float flag is stale once a cycle has begun; qualify with phase
  assign floated = float_q_i && phase_may_grant(phase_i);
  assign den_act = !floated && (den_mid_i || (phase_i == PH_T2 && dir_i));

  assign float_o = floated;
  assign dt_r_o  = floated | dir_i;
  assign den_no  = ~den_act;
  assign done_o  = (phase_i == PH_T4);
endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
  import bus_cyc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [KIND_W-1:0] kind_i,
  input  logic              ready_i,
  input  logic              hold_i,
  output logic              dt_r_o,
  output logic              den_no,
  output logic              hlda_o,
  output logic              float_o,
  output logic              done_o
);
  phase_e phase;
  logic   dir, den_mid, hlda, float_q;

  bus_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .kind_i  (kind_i),
    .ready_i (ready_i),
    .hlda_i  (hlda),
    .phase_o (phase),
    .dir_o   (dir)
  );

  bus_mid_stage u_mid (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .phase_i   (phase),
    .hold_i    (hold_i),
    .den_mid_o (den_mid),
    .hlda_o    (hlda),
    .float_o   (float_q)
  );

  bus_out_drive u_out (
    .phase_i   (phase),
    .dir_i     (dir),
    .den_mid_i (den_mid),
    .float_q_i (float_q),
    .dt_r_o    (dt_r_o),
    .den_no    (den_no),
    .float_o   (float_o),
    .done_o    (done_o)
  );

  assign hlda_o = hlda;
endmodule

// File: rtl/bus_cycle_ctrl_chk.sv
module bus_cycle_ctrl_chk
  import bus_cyc_pkg::*;
(
  input logic   clk_i,
  input logic   rst_ni,
  input logic   ready_i,
  input logic   hold_i,
  input logic   dt_r_o,
  input logic   den_no,
  input logic   hlda_o,
  input logic   float_o,
  input logic   done_o,
  input phase_e phase_i
);
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R1

  AST_DEN_IDLE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_TI) |-> den_no); // R2

  AST_WAIT_INSERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((phase_i == PH_T3 || phase_i == PH_TW) && !ready_i) |=> (phase_i == PH_TW)); // R5

  AST_GRANT_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hlda_o) |-> (phase_i == PH_TI || phase_i == PH_T4)); // R6

  AST_FLOAT_PARKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    float_o |-> (dt_r_o && den_no)); // R7

  AST_HLDA_NEEDS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hlda_o |-> hold_i); // R8

  AST_NO_START_GRANTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hlda_o && (phase_i == PH_TI || phase_i == PH_T4)) |=> (phase_i == PH_TI)); // R9
endmodule

bind bus_cycle_ctrl bus_cycle_ctrl_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ready_i (ready_i),
  .hold_i  (hold_i),
  .dt_r_o  (dt_r_o),
  .den_no  (den_no),
  .hlda_o  (hlda_o),
  .float_o (float_o),
  .done_o  (done_o),
  .phase_i (phase)
);

// File: tb/bus_cycle_ctrl_test.sv
`timescale 1ns/1ps
module bus_cycle_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0;
  logic [2:0] kind = 3'b000;
  logic       ready = 1'b1;
  logic       hold = 1'b0;
  logic       dt_r, den_n, hlda, flt, done;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  bus_cycle_ctrl uut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .req_i   (req),
    .kind_i  (kind),
    .ready_i (ready),
    .hold_i  (hold),
    .dt_r_o  (dt_r),
    .den_no  (den_n),
    .hlda_o  (hlda),
    .float_o (flt),
    .done_o  (done)
  );

  // behavioural reference: bus state as small integers
  localparam int S_IDLE = 0, S_1 = 1, S_2 = 2, S_3 = 3, S_W = 4, S_4 = 5;
  int m_st = S_IDLE;
  bit m_wr = 1'b0;
  bit m_hlda = 1'b0;
  bit m_fl = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = S_IDLE;
      m_wr = 1'b0;
    end else begin
      case (m_st)
        S_IDLE, S_4: begin
          if (req && !m_hlda) begin
            m_st = S_1;
            m_wr = (kind == 3'b010) || (kind == 3'b110);
          end else m_st = S_IDLE;
        end
        S_1: m_st = S_2;
        S_2: m_st = S_3;
        default: m_st = ready ? S_4 : S_W;
      endcase
    end
  end

  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hlda = 1'b0;
      m_fl = 1'b0;
    end else begin
      if (m_hlda) m_hlda = hold;
      else if (hold && (m_st == S_IDLE || m_st == S_4)) begin
        m_hlda = 1'b1;
        m_fl = 1'b1;
      end
      if (m_st != S_IDLE && m_st != S_4) m_fl = 1'b0;
    end
  end

  task automatic chk(input string tag, input string sig, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at %0t: actual %b expected %b", tag, sig, $time, act, exp);
    end
  endtask

  task automatic compare(input bit first_half);
    bit e_fl, e_den;
    string t_den;
    e_fl  = m_fl && (m_st == S_IDLE || m_st == S_4);
    e_den = !e_fl && ((m_st == S_2 && (m_wr || !first_half)) || m_st == S_3 ||
                      m_st == S_W || (m_st == S_4 && first_half));
    t_den = (m_st == S_W) ? "R5" : (m_wr ? "R3" : "R2");
    if (!rst_n) begin
      chk("R10", "den_no", den_n, 1'b1);
      chk("R10", "dt_r_o", dt_r, 1'b0);
      chk("R10", "hlda_o", hlda, 1'b0);
      chk("R10", "float_o", flt, 1'b0);
      chk("R10", "done_o", done, 1'b0);
    end else begin
      chk(t_den, "den_no", den_n, !e_den);
      chk(e_fl ? "R7" : "R4", "dt_r_o", dt_r, e_fl ? 1'b1 : m_wr);
      chk("R6 R8", "hlda_o", hlda, m_hlda);
      chk("R7 R8", "float_o", flt, e_fl);
      chk("R1 R9", "done_o", done, m_st == S_4);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk); #3; compare(1'b1);
      @(negedge clk); #3; compare(1'b0);
    end
  end

  task automatic tick();
    @(posedge clk); #5;
  endtask

  // one bus cycle with w wait states; returns 5 ns into T4
  task automatic run_cycle(input logic [2:0] k, input int w);
    req = 1'b1;
    kind = k;
    do tick(); while (m_st != S_1);
    req = 1'b0;
    tick();                          // T2
    tick();                          // T3
    ready = (w == 0);
    for (int i = 0; i < w; i++) begin
      tick();                        // TW
      ready = (i == w - 1);
    end
    tick();                          // T4
    ready = 1'b1;
  endtask

  initial begin
    repeat (3) tick();               // R10 checked while held in reset
    rst_n = 1'b1;
    tick();
    run_cycle(3'b101, 0);            // R2 memory read
    tick();
    run_cycle(3'b110, 2);            // R3 R5 memory write with waits
    run_cycle(3'b001, 1);            // R1 back-to-back I/O read
    run_cycle(3'b010, 0);            // R4 I/O write
    tick();
    run_cycle(3'b000, 3);            // R2 interrupt acknowledge
    repeat (2) tick();
    // R6 R7: grant from idle, R8 release without a request keeps float
    hold = 1'b1;
    repeat (4) tick();
    hold = 1'b0;
    repeat (3) tick();
    run_cycle(3'b101, 0);
    // R6: hold raised mid-cycle, grant and done share T4, request waits (R9)
    fork
      run_cycle(3'b110, 1);
      begin tick(); tick(); hold = 1'b1; end
    join
    fork
      run_cycle(3'b001, 0);
      begin repeat (5) tick(); hold = 1'b0; end
    join
    // R8: hold dropped then raised again before any cycle
    hold = 1'b1;
    repeat (2) tick();
    hold = 1'b0;
    tick();
    hold = 1'b1;
    repeat (2) tick();
    hold = 1'b0;
    run_cycle(3'b010, 0);
    repeat (3) tick();
    // R10: reset in the middle of a cycle
    req = 1'b1;
    kind = 3'b110;
    repeat (3) tick();
    req = 1'b0;
    rst_n = 1'b0;
    repeat (2) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule